// File: doc/BRIEF.md
# Serial NOR Flash Command Engine

This block is the byte-level command engine of a serial NOR flash model. A host, or the bit shifter in front of the block, holds `sel` high for the whole transaction and pulses `byte_stb` once for each byte it shifts in on `tx_byte`. The first byte after selection is taken as an opcode. Later bytes are an address, dummy bytes or data, depending on that opcode. For every accepted byte the engine returns one response byte on `rsp_byte`, with `rsp_vld` high for one cycle. The response appears on the clock edge that follows the strobe.

The storage is a small internal byte array, `MEM_BYTES` entries, with a power-of-two size. The engine supports an identification read, plain and fast reads with 3- or 4-byte addresses, page program, bulk erase, write enable and disable, a status read, and a two-step reset. An opcode the engine does not know turns the rest of the transaction into a stream of zero responses. The trailing bytes of a command the engine does not recognise can then never start a program or an erase by accident.

Top module: `spinor_cmd_engine`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rsp_vld` and `erase_rej` are 0. Every storage byte resets to 0xFF and the write-enable latch resets to 0.
- R2: A `byte_stb` pulse while `sel` is high makes `rsp_vld` high in the next cycle, with the response byte on `rsp_byte`. A strobe while `sel` is low produces no response and changes no state. The response to an opcode, address or dummy byte is 0x00.
- R3: Opcode 0x9F returns exactly six bytes. The first `ID_LEN` bytes are `ID_CODE`, most significant byte first, and the rest are 0x00. The byte after the sixth is decoded as a new opcode.
- R4: Any opcode not listed in these requirements makes every later byte of the same selection return 0x00. None of those later bytes is decoded, so for example 0x06 does not set write enable. Deselection ends this state.
- R5: Opcode 0x66 arms a reset latch. Opcode 0x99, received while the latch is armed, clears write enable. Any opcode other than 0x99 disarms the latch, and 0x99 without the latch has no effect. The two opcodes may arrive in the same selection or in separate selections.
- R6: Opcode 0x06 sets write enable and 0x04 clears it. Opcode 0x05 returns the status byte on every later byte of the selection, with write enable in bit 1 and all other bits 0.
- R7: Bulk erase (0xC7 or 0x60) with write enable set writes 0xFF to every byte and clears write enable. Without write enable the storage is left unchanged, and `erase_rej` is high in the same cycle as the response.
- R8: Page program (0x02 with a 3-byte address, or 0x12 with a 4-byte address) with write enable set stores old AND data at the current address for each data byte. The address then advances and wraps modulo `MEM_BYTES`. Write enable clears at the deselection that ends the program. Without write enable the data bytes are ignored and return 0x00.
- R9: Read (0x03 with a 3-byte address, or 0x13 with a 4-byte address) returns storage bytes from the current address, advancing and wrapping modulo `MEM_BYTES`. Address bytes arrive most significant first, and only the low log2(`MEM_BYTES`) address bits are used.
- R10: The fast reads 0x0B, 0x3B and 0x6B expect one dummy byte after the 3-byte address. Their 4-byte-address forms 0x0C, 0x3C and 0x6C also expect one. The reads 0xBB and 0xBC expect two dummy bytes. Each dummy byte returns 0x00, and storage data follows.
- R11: Deselection returns the engine to opcode decode, even in the middle of an address. The first byte after reselection is always an opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Chip select level, high while a transaction is in progress |
| byte_stb | input | 1 | One-cycle strobe: `tx_byte` holds a new byte |
| tx_byte | input | 8 | Byte shifted in from the host |
| rsp_vld | output | 1 | Response byte valid, one cycle after a strobe |
| rsp_byte | output | 8 | Response byte for the last strobe |
| erase_rej | output | 1 | Pulse: bulk erase refused because write enable was clear |

## Verification
On every cycle the assertions check four things. A response follows exactly the strobes made while selected. The zero-lock state holds and returns only zeros until deselection. Deselection always returns the engine to opcode decode. Erases and program writes happen only with write enable set, and a refused erase is flagged only when write enable was clear.

Data-path results need the bench's scenarios. These are the six-byte identification padding and the opcode after it, and program AND semantics across transactions. They also cover address wrap and truncation, the dummy-byte counts of each fast-read form, and the ordering rules of the two-step reset.

// File: rtl/spinor_pkg.sv
package spinor_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DUMMY,
        ST_READ,
        ST_PROG,
        ST_IDOUT,
        ST_STAT,
        ST_ZERO
    } eng_state_t;

    localparam int ID_RSP_BYTES = 6;

    localparam logic [7:0] OPC_WR_EN      = 8'h06;
    localparam logic [7:0] OPC_WR_DIS     = 8'h04;
    localparam logic [7:0] OPC_STATUS     = 8'h05;
    localparam logic [7:0] OPC_IDENT      = 8'h9F;
    localparam logic [7:0] OPC_RD         = 8'h03;
    localparam logic [7:0] OPC_RD_W       = 8'h13;
    localparam logic [7:0] OPC_RD_FAST    = 8'h0B;
    localparam logic [7:0] OPC_RD_FAST_W  = 8'h0C;
    localparam logic [7:0] OPC_RD_X2      = 8'h3B;
    localparam logic [7:0] OPC_RD_X2_W    = 8'h3C;
    localparam logic [7:0] OPC_RD_X4      = 8'h6B;
    localparam logic [7:0] OPC_RD_X4_W    = 8'h6C;
    localparam logic [7:0] OPC_RD_IO2     = 8'hBB;
    localparam logic [7:0] OPC_RD_IO2_W   = 8'hBC;
    localparam logic [7:0] OPC_PROG       = 8'h02;
    localparam logic [7:0] OPC_PROG_W     = 8'h12;
    localparam logic [7:0] OPC_ERASE_ALL  = 8'hC7;
    localparam logic [7:0] OPC_ERASE_ALT  = 8'h60;
    localparam logic [7:0] OPC_RST_ARM    = 8'h66;
    localparam logic [7:0] OPC_RST_DO     = 8'h99;

    function automatic logic op_is_read(input logic [7:0] op);
        case (op)
            OPC_RD, OPC_RD_W, OPC_RD_FAST, OPC_RD_FAST_W, OPC_RD_X2, OPC_RD_X2_W,
            OPC_RD_X4, OPC_RD_X4_W, OPC_RD_IO2, OPC_RD_IO2_W: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic op_is_prog(input logic [7:0] op);
        return (op == OPC_PROG) || (op == OPC_PROG_W);
    endfunction

    function automatic logic [2:0] op_addr_bytes(input logic [7:0] op);
        case (op)
            OPC_RD_W, OPC_RD_FAST_W, OPC_RD_X2_W, OPC_RD_X4_W,
            OPC_RD_IO2_W, OPC_PROG_W: return 3'd4;
            default: return 3'd3;
        endcase
    endfunction

    function automatic logic [1:0] op_dummy_bytes(input logic [7:0] op);
        case (op)
            OPC_RD_FAST, OPC_RD_FAST_W, OPC_RD_X2, OPC_RD_X2_W,
            OPC_RD_X4, OPC_RD_X4_W: return 2'd1;
            OPC_RD_IO2, OPC_RD_IO2_W: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/spinor_id_rom.sv
module spinor_id_rom #(
    parameter int          ID_LEN  = 3,
    parameter logic [8*ID_LEN-1:0] ID_CODE = '0
) (
    output logic [8*spinor_pkg::ID_RSP_BYTES-1:0] id_flat
);
    localparam int NB = spinor_pkg::ID_RSP_BYTES;

    for (genvar j = 0; j < NB; j++) begin : g_byte
        if (j < ID_LEN) begin : g_code
            assign id_flat[8*j +: 8] = ID_CODE[8*(ID_LEN-1-j) +: 8];
        end else begin : g_pad
            assign id_flat[8*j +: 8] = 8'h00;
        end
    end
endmodule

// File: rtl/spinor_store.sv
module spinor_store #(
    parameter int MEM_BYTES = 256,
    localparam int ADDR_W = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              erase_go,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data
);
    logic [7:0] mem [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (rst || erase_go) begin
            for (int i = 0; i < MEM_BYTES; i++) begin
                mem[i] <= 8'hFF;
            end
        end else if (wr_en) begin
            mem[addr] <= mem[addr] & wr_data;
        end
    end

    assign rd_data = mem[addr];
endmodule

// File: rtl/spinor_cmd_fsm.sv
module spinor_cmd_fsm
    import spinor_pkg::*;
#(
    parameter int MEM_BYTES = 256,
    localparam int ADDR_W = $clog2(MEM_BYTES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sel,
    input  logic                     byte_stb,
    input  logic [7:0]               tx_byte,
    input  logic [7:0]               rd_data,
    input  logic [8*ID_RSP_BYTES-1:0] id_flat,
    output logic [ADDR_W-1:0]        addr,
    output logic                     wr_en,
    output logic                     erase_go,
    output logic                     rsp_vld,
    output logic [7:0]               rsp_byte,
    output logic                     erase_rej,
    output eng_state_t               state,
    output logic                     wel
);
    eng_state_t        state_q;
    logic [7:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        cnt_q;
    logic              wel_q;
    logic              rst_arm_q;
    logic              take;
    logic              is_erase;

    assign take     = sel && byte_stb;
    assign is_erase = (tx_byte == OPC_ERASE_ALL) || (tx_byte == OPC_ERASE_ALT);
    assign addr     = addr_q;
    assign wr_en    = take && (state_q == ST_PROG);
    assign erase_go = take && (state_q == ST_IDLE) && is_erase && wel_q;
    assign state    = state_q;
    assign wel      = wel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            op_q      <= 8'h00;
            addr_q    <= '0;
            cnt_q     <= 3'd0;
            wel_q     <= 1'b0;
            rst_arm_q <= 1'b0;
            rsp_vld   <= 1'b0;
            rsp_byte  <= 8'h00;
            erase_rej <= 1'b0;
        end else begin
            rsp_vld   <= 1'b0;
            erase_rej <= 1'b0;
            if (!sel) begin
                state_q <= ST_IDLE;
                if (state_q == ST_PROG) wel_q <= 1'b0;
            end else if (byte_stb) begin
                rsp_vld  <= 1'b1;
                rsp_byte <= 8'h00;
                case (state_q)
                    ST_IDLE: begin
                        op_q      <= tx_byte;
                        rst_arm_q <= (tx_byte == OPC_RST_ARM);
                        if (tx_byte == OPC_WR_EN) begin
                            wel_q <= 1'b1;
                        end else if (tx_byte == OPC_WR_DIS) begin
                            wel_q <= 1'b0;
                        end else if (tx_byte == OPC_STATUS) begin
                            state_q <= ST_STAT;
                        end else if (tx_byte == OPC_IDENT) begin
                            state_q <= ST_IDOUT;
                            cnt_q   <= 3'd0;
                        end else if (is_erase) begin
                            if (wel_q) wel_q <= 1'b0;
                            else       erase_rej <= 1'b1;
                        end else if (tx_byte == OPC_RST_DO) begin
                            if (rst_arm_q) wel_q <= 1'b0;
                        end else if (tx_byte == OPC_RST_ARM) begin
                            state_q <= ST_IDLE;
                        end else if (op_is_read(tx_byte) || op_is_prog(tx_byte)) begin
                            state_q <= ST_ADDR;
                            cnt_q   <= op_addr_bytes(tx_byte) - 3'd1;
                            addr_q  <= '0;
                        end else begin
                            state_q <= ST_ZERO;
                        end
                    end
                    ST_ADDR: begin
                        addr_q <= ADDR_W'({addr_q, tx_byte});
                        if (cnt_q != 3'd0) begin
                            cnt_q <= cnt_q - 3'd1;
                        end else if (op_dummy_bytes(op_q) != 2'd0) begin
                            state_q <= ST_DUMMY;
                            cnt_q   <= {1'b0, op_dummy_bytes(op_q)} - 3'd1;
                        end else if (op_is_prog(op_q)) begin
                            state_q <= wel_q ? ST_PROG : ST_ZERO;
                        end else begin
                            state_q <= ST_READ;
                        end
                    end
                    ST_DUMMY: begin
                        if (cnt_q == 3'd0) state_q <= ST_READ;
                        else               cnt_q   <= cnt_q - 3'd1;
                    end
                    ST_READ: begin
                        rsp_byte <= rd_data;
                        addr_q   <= addr_q + ADDR_W'(1);
                    end
                    ST_PROG: begin
                        addr_q <= addr_q + ADDR_W'(1);
                    end
                    ST_IDOUT: begin
                        rsp_byte <= id_flat[8*cnt_q +: 8];
                        if (cnt_q == 3'(ID_RSP_BYTES - 1)) begin
                            state_q <= ST_IDLE;
                            cnt_q   <= 3'd0;
                        end else begin
                            cnt_q <= cnt_q + 3'd1;
                        end
                    end
                    ST_STAT: begin
                        rsp_byte <= {6'b0, wel_q, 1'b0};
                    end
                    default: begin
                        rsp_byte <= 8'h00;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/spinor_cmd_engine.sv
module spinor_cmd_engine
    import spinor_pkg::*;
#(
    parameter int                  MEM_BYTES = 256,
    parameter int                  ID_LEN    = 3,
    parameter logic [8*ID_LEN-1:0] ID_CODE   = 24'h5A3108
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  logic       byte_stb,
    input  logic [7:0] tx_byte,
    output logic       rsp_vld,
    output logic [7:0] rsp_byte,
    output logic       erase_rej
);
    localparam int ADDR_W = $clog2(MEM_BYTES);

    logic [8*ID_RSP_BYTES-1:0] id_flat;
    logic [ADDR_W-1:0]         addr;
    logic [7:0]                rd_data;
    logic                      wr_en;
    logic                      erase_go;
    logic                      wel;
    eng_state_t                state;

    spinor_id_rom #(.ID_LEN(ID_LEN), .ID_CODE(ID_CODE)) u_id (
        .id_flat (id_flat)
    );

    spinor_store #(.MEM_BYTES(MEM_BYTES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .erase_go (erase_go),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (tx_byte),
        .rd_data  (rd_data)
    );

    spinor_cmd_fsm #(.MEM_BYTES(MEM_BYTES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .byte_stb  (byte_stb),
        .tx_byte   (tx_byte),
        .rd_data   (rd_data),
        .id_flat   (id_flat),
        .addr      (addr),
        .wr_en     (wr_en),
        .erase_go  (erase_go),
        .rsp_vld   (rsp_vld),
        .rsp_byte  (rsp_byte),
        .erase_rej (erase_rej),
        .state     (state),
        .wel       (wel)
    );
endmodule

// File: rtl/spinor_cmd_engine_chk.sv
module spinor_cmd_engine_chk
    import spinor_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sel,
    input logic       byte_stb,
    input logic       rsp_vld,
    input logic [7:0] rsp_byte,
    input logic       erase_rej,
    input eng_state_t state,
    input logic       wel,
    input logic       erase_go,
    input logic       wr_en
);
    // R2: a response follows every selected strobe
    a_r2_rsp_after_stb: assert property (@(posedge clk) disable iff (rst)
        (sel && byte_stb) |=> rsp_vld);

    // R2: no response without a selected strobe
    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !(sel && byte_stb) |=> !rsp_vld);

    // R4: the zero-lock state persists while selected
    a_r4_zero_lock_holds: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ZERO && sel) |=> (state == ST_ZERO));

    // R4: the zero-lock state answers only zeros
    a_r4_zero_lock_data: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ZERO && sel && byte_stb) |=> (rsp_byte == 8'h00));

    // R6: the status byte reports write enable in bit 1
    a_r6_status_byte: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STAT && sel && byte_stb) |=> (rsp_byte == {6'b0, $past(wel), 1'b0}));

    // R7: an erase happens only with write enable and clears it
    a_r7_erase_needs_wel: assert property (@(posedge clk) disable iff (rst)
        erase_go |-> wel);
    a_r7_erase_clears_wel: assert property (@(posedge clk) disable iff (rst)
        erase_go |=> !wel);

    // R7: a refusal is flagged only when write enable was clear
    a_r7_reject_only_without_wel: assert property (@(posedge clk) disable iff (rst)
        erase_rej |-> !$past(wel));

    // R8: program writes require write enable
    a_r8_prog_needs_wel: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wel);

    // R11: deselection returns to opcode decode
    a_r11_deselect_idle: assert property (@(posedge clk) disable iff (rst)
        !sel |=> (state == ST_IDLE));
endmodule

bind spinor_cmd_engine spinor_cmd_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .byte_stb  (byte_stb),
    .rsp_vld   (rsp_vld),
    .rsp_byte  (rsp_byte),
    .erase_rej (erase_rej),
    .state     (state),
    .wel       (wel),
    .erase_go  (erase_go),
    .wr_en     (wr_en)
);

// File: tb/test_spinor_cmd_engine.sv
module test_spinor_cmd_engine;

    typedef struct packed {
        logic       desel;
        logic [7:0] tx;
        logic [7:0] exp;
        logic       rej;
        logic [7:0] req;
    } vec_t;

    function automatic vec_t v(input logic d, input logic [7:0] t, input logic [7:0] e,
                               input logic j, input logic [7:0] r);
        return '{desel: d, tx: t, exp: e, rej: j, req: r};
    endfunction

    localparam int N = 137;

    localparam vec_t VEC [N] = '{
        // R1 / R6: write enable is clear after reset (2)
        v(1,8'h05,8'h00,0,6), v(0,8'h00,8'h00,0,1),
        // R3: six-byte identification, then a fresh opcode (9)
        v(1,8'h9F,8'h00,0,3), v(0,8'h00,8'h5A,0,3), v(0,8'h00,8'h31,0,3),
        v(0,8'h00,8'h08,0,3), v(0,8'h00,8'h00,0,3), v(0,8'h00,8'h00,0,3),
        v(0,8'h00,8'h00,0,3), v(0,8'h05,8'h00,0,3), v(0,8'h00,8'h00,0,3),
        // R6: write enable shows in status (3)
        v(1,8'h06,8'h00,0,6), v(1,8'h05,8'h00,0,6), v(0,8'h00,8'h02,0,6),
        // R8: program 3C,F0 at 0x10, enable cleared afterwards (8)
        v(1,8'h02,8'h00,0,8), v(0,8'h00,8'h00,0,8), v(0,8'h00,8'h00,0,8),
        v(0,8'h10,8'h00,0,8), v(0,8'h3C,8'h00,0,8), v(0,8'hF0,8'h00,0,8),
        v(1,8'h05,8'h00,0,8), v(0,8'h00,8'h00,0,8),
        // R9: read back from 0x10 (7)
        v(1,8'h03,8'h00,0,9), v(0,8'h00,8'h00,0,9), v(0,8'h00,8'h00,0,9),
        v(0,8'h10,8'h00,0,9), v(0,8'h00,8'h3C,0,9), v(0,8'h00,8'hF0,0,9),
        v(0,8'h00,8'hFF,0,9),
        // R8: program without write enable is ignored (10)
        v(1,8'h02,8'h00,0,8), v(0,8'h00,8'h00,0,8), v(0,8'h00,8'h00,0,8),
        v(0,8'h10,8'h00,0,8), v(0,8'h00,8'h00,0,8),
        v(1,8'h03,8'h00,0,8), v(0,8'h00,8'h00,0,8), v(0,8'h00,8'h00,0,8),
        v(0,8'h10,8'h00,0,8), v(0,8'h00,8'h3C,0,8),
        // R8: program ANDs into the old value (11)
        v(1,8'h06,8'h00,0,8), v(1,8'h02,8'h00,0,8), v(0,8'h00,8'h00,0,8),
        v(0,8'h00,8'h00,0,8), v(0,8'h10,8'h00,0,8), v(0,8'hC3,8'h00,0,8),
        v(1,8'h03,8'h00,0,8), v(0,8'h00,8'h00,0,8), v(0,8'h00,8'h00,0,8),
        v(0,8'h10,8'h00,0,8), v(0,8'h00,8'h00,0,8),
        // R8 / R9: address wrap and truncation of high address bits (18)
        v(1,8'h06,8'h00,0,8), v(1,8'h02,8'h00,0,8), v(0,8'h00,8'h00,0,8),
        v(0,8'h00,8'h00,0,8), v(0,8'hFF,8'h00,0,8), v(0,8'h12,8'h00,0,8),
        v(0,8'h34,8'h00,0,8),
        v(1,8'h03,8'h00,0,9), v(0,8'h00,8'h00,0,9), v(0,8'h00,8'h00,0,9),
        v(0,8'hFF,8'h00,0,9), v(0,8'h00,8'h12,0,9), v(0,8'h00,8'h34,0,9),
        v(1,8'h03,8'h00,0,9), v(0,8'h7F,8'h00,0,9), v(0,8'h01,8'h00,0,9),
        v(0,8'hFF,8'h00,0,9), v(0,8'h00,8'h12,0,9),
        // R10: dummy bytes of the fast-read forms (26)
        v(1,8'h0B,8'h00,0,10), v(0,8'h00,8'h00,0,10), v(0,8'h00,8'h00,0,10),
        v(0,8'h11,8'h00,0,10), v(0,8'h00,8'h00,0,10), v(0,8'h00,8'hF0,0,10),
        v(1,8'hBB,8'h00,0,10), v(0,8'h00,8'h00,0,10), v(0,8'h00,8'h00,0,10),
        v(0,8'h11,8'h00,0,10), v(0,8'h00,8'h00,0,10), v(0,8'h00,8'h00,0,10),
        v(0,8'h00,8'hF0,0,10),
        v(1,8'h13,8'h00,0,10), v(0,8'h00,8'h00,0,10), v(0,8'h00,8'h00,0,10),
        v(0,8'h00,8'h00,0,10), v(0,8'h11,8'h00,0,10), v(0,8'h00,8'hF0,0,10),
        v(1,8'h0C,8'h00,0,10), v(0,8'h00,8'h00,0,10), v(0,8'h00,8'h00,0,10),
        v(0,8'h00,8'h00,0,10), v(0,8'h11,8'h00,0,10), v(0,8'h00,8'h00,0,10),
        v(0,8'h00,8'hF0,0,10),
        // R4: unknown opcode locks to zeros, trailing bytes not decoded (7)
        v(1,8'h5E,8'h00,0,4), v(0,8'h06,8'h00,0,4), v(0,8'h05,8'h00,0,4),
        v(0,8'h00,8'h00,0,4), v(0,8'h9F,8'h00,0,4),
        v(1,8'h05,8'h00,0,4), v(0,8'h00,8'h00,0,4),
        // R5: two-step reset, disarm by another opcode, same-select pair (16)
        v(1,8'h06,8'h00,0,5), v(1,8'h66,8'h00,0,5), v(1,8'h99,8'h00,0,5),
        v(1,8'h05,8'h00,0,5), v(0,8'h00,8'h00,0,5),
        v(1,8'h06,8'h00,0,5), v(1,8'h66,8'h00,0,5), v(1,8'h05,8'h00,0,5),
        v(0,8'h00,8'h02,0,5), v(1,8'h99,8'h00,0,5), v(1,8'h05,8'h00,0,5),
        v(0,8'h00,8'h02,0,5),
        v(1,8'h66,8'h00,0,5), v(0,8'h99,8'h00,0,5), v(0,8'h05,8'h00,0,5),
        v(0,8'h00,8'h00,0,5),
        // R7: refused erase keeps data, accepted erase fills 0xFF (15)
        v(1,8'hC7,8'h00,1,7),
        v(1,8'h03,8'h00,0,7), v(0,8'h00,8'h00,0,7), v(0,8'h00,8'h00,0,7),
        v(0,8'h11,8'h00,0,7), v(0,8'h00,8'hF0,0,7),
        v(1,8'h06,8'h00,0,7), v(1,8'hC7,8'h00,0,7),
        v(1,8'h03,8'h00,0,7), v(0,8'h00,8'h00,0,7), v(0,8'h00,8'h00,0,7),
        v(0,8'h11,8'h00,0,7), v(0,8'h00,8'hFF,0,7),
        v(1,8'h05,8'h00,0,7), v(0,8'h00,8'h00,0,7),
        // R11: deselect in the middle of an address (5)
        v(1,8'h03,8'h00,0,11), v(0,8'h00,8'h00,0,11), v(0,8'h00,8'h00,0,11),
        v(1,8'h05,8'h00,0,11), v(0,8'h00,8'h00,0,11)
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0;
    logic       byte_stb = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       rsp_vld;
    logic [7:0] rsp_byte;
    logic       erase_rej;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spinor_cmd_engine i_spinor_cmd_engine (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .byte_stb  (byte_stb),
        .tx_byte   (tx_byte),
        .rsp_vld   (rsp_vld),
        .rsp_byte  (rsp_byte),
        .erase_rej (erase_rej)
    );

    task automatic deselect();
        sel      = 1'b0;
        byte_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        sel      = 1'b1;
        byte_stb = 1'b1;
        tx_byte  = b;
        @(negedge clk);
        byte_stb = 1'b0;
    endtask

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {vld,rej,byte} actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: no response and no refusal straight after reset
        check("R1", {rsp_vld, erase_rej, 8'h00}, 10'h000);

        for (int k = 0; k < N; k++) begin
            if (VEC[k].desel) deselect();
            send(VEC[k].tx);
            check($sformatf("R%0d vec %0d", VEC[k].req, k),
                  {rsp_vld, erase_rej, rsp_byte}, {1'b1, VEC[k].rej, VEC[k].exp});
        end

        // R2: a strobe with select low gives no response and sets nothing
        deselect();
        byte_stb = 1'b1;
        tx_byte  = 8'h06;
        @(negedge clk);
        byte_stb = 1'b0;
        check("R2 unselected strobe", {rsp_vld, 9'h000}, 10'h000);
        send(8'h05);
        send(8'h00);
        check("R2 enable untouched", {rsp_vld, erase_rej, rsp_byte}, {2'b10, 8'h00});

        // R2: response valid lasts exactly one cycle
        @(negedge clk);
        check("R2 single pulse", {rsp_vld, 9'h000}, 10'h000);

        deselect();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule